// File: doc/BRIEF.md
# Burst-Capable PWM Output Generator

This block produces a pulse-width-modulated logic waveform for a single digital output channel. Software programs the period and the pulse width as whole counts of the block's clock. It also picks whether the channel runs until told to stop or emits a fixed number of full periods. Polarity selects an active-high or an active-low pulse. Each period opens with its active phase, which lasts pulse-width counts, and closes with an inactive phase for the remaining counts.

A run begins only on a start strobe and ends on a stop strobe or when the last burst period completes. While idle the output rests at the inactive level of the present polarity setting. A busy flag reports a run in progress, and a sticky done flag reports that a burst finished on its own. Period, pulse width and polarity are captured into shadow registers at the start of a run and again at every period boundary. A value written mid-period therefore never cuts a pulse short. Run mode and burst count are captured only at start.

Top module: `pwm_burst_gen`

## Requirements
- R1: After reset, busy and done are 0. While idle, pwm_out equals cfg_polarity as sampled one clock earlier (the inactive level).
- R2: A start pulse seen while idle (with stop low) sets busy at that edge and clears done. The first active count appears on pwm_out one clock later.
- R3: With period P and width W (0 < W < P), the waveform repeats every P clocks: active for the first W clocks, then inactive for P-W clocks.
- R4: A width of 0 gives a constantly inactive output during a run. A width of P or more gives a constantly active output.
- R5: In continuous mode (cfg_mode = 0), busy stays high and the waveform repeats until a stop pulse.
- R6: In burst mode (cfg_mode = 1), exactly N full periods are emitted, where N is cfg_burst and a value of 0 counts as 1. busy falls at the edge ending the last period, done is set at that same edge, and the output then returns to inactive.
- R7: cfg_polarity = 0 gives an active-high pulse. cfg_polarity = 1 inverts both levels, so the pulse is low and the rest level is high.
- R8: A stop pulse clears busy at its edge without setting done. pwm_out is inactive from the next clock on. Stop takes priority over start.
- R9: New period and width values written during a run take effect only from the next period boundary. The period in progress completes with its old values.
- R10: A start pulse while busy is ignored: it neither restarts the period nor disturbs the waveform.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Timebase clock; one count per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_mode | input | 1 | 0 = continuous, 1 = fixed burst |
| cfg_polarity | input | 1 | 0 = active-high pulse, 1 = active-low pulse |
| cfg_period | input | CNT_W | Period in clock counts |
| cfg_width | input | CNT_W | Active pulse width in clock counts |
| cfg_burst | input | BURST_W | Number of periods in burst mode |
| start | input | 1 | Single-cycle start strobe |
| stop | input | 1 | Single-cycle stop strobe |
| pwm_out | output | 1 | PWM waveform, one clock behind the internal phase |
| busy | output | 1 | High while a run is in progress |
| done | output | 1 | Sticky: a burst completed on its own |

## Verification
The assertions assume a period of at least 1 whenever the period shadow is non-zero. They also assume that start and stop are single-cycle strobes sampled on the rising edge, and that configuration settles a half cycle before the edge that captures it. The bench meets these assumptions by changing all inputs on the falling edge, keeping every period between 3 and 6 counts, and pulsing start for exactly one cycle. Its stop and mid-run reconfiguration land at known period phases. They are kept away from the boundary edge, so the expected waveform can be predicted count by count.

// File: rtl/pwm_burst_pkg.sv
package pwm_burst_pkg;
   typedef enum logic {
      RUN_FOREVER = 1'b0,
      RUN_BURST   = 1'b1
   } run_mode_e;
endpackage

// File: rtl/pwm_shadow_regs.sv
module pwm_shadow_regs #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] per_in,
   input  logic [CNT_W-1:0] wid_in,
   input  logic             pol_in,
   output logic [CNT_W-1:0] per_sh,
   output logic [CNT_W-1:0] wid_sh,
   output logic             pol_sh
);
   // Captured at run start and at each period boundary only
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         per_sh <= '0;
         wid_sh <= '0;
         pol_sh <= 1'b0;
      end else if (load) begin
         per_sh <= per_in;
         wid_sh <= wid_in;
         pol_sh <= pol_in;
      end
   end
endmodule

// File: rtl/pwm_period_counter.sv
module pwm_period_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             run,
   input  logic [CNT_W-1:0] per_sh,
   output logic [CNT_W-1:0] cnt_q,
   output logic             wrap
);
   localparam int EXT_W = CNT_W + 1;

   logic [EXT_W-1:0] cnt_plus1;

   assign cnt_plus1 = {1'b0, cnt_q} + EXT_W'(1);
   // A zero period behaves as a one-count period
   assign wrap      = run && (cnt_plus1 >= {1'b0, per_sh});

   always_ff @(posedge clk) begin
      if (!rst_n)      cnt_q <= '0;
      else if (clr)    cnt_q <= '0;
      else if (!run)   cnt_q <= '0;
      else if (wrap)   cnt_q <= '0;
      else             cnt_q <= cnt_plus1[CNT_W-1:0];
   end

   p_cnt_below_period_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (run && per_sh != '0) |-> (cnt_q < per_sh));
endmodule

// File: rtl/pwm_burst_seq.sv
module pwm_burst_seq
   import pwm_burst_pkg::*;
#(
   parameter int BURST_W = 16
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               stop,
   input  logic               mode_in,
   input  logic [BURST_W-1:0] burst_in,
   input  logic               wrap,
   output logic               accept,
   output logic               busy_q,
   output logic               done_q
);
   run_mode_e          mode_q;
   logic [BURST_W-1:0] left_q;
   logic               finish;

   assign accept = start && !stop && !busy_q;
   assign finish = busy_q && wrap && (mode_q == RUN_BURST) && (left_q <= BURST_W'(1));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q <= 1'b0;
         done_q <= 1'b0;
         mode_q <= RUN_FOREVER;
         left_q <= '0;
      end else begin
         if (accept) begin
            busy_q <= 1'b1;
            done_q <= 1'b0;
            mode_q <= run_mode_e'(mode_in);
            left_q <= burst_in;
         end else if (stop) begin
            busy_q <= 1'b0;
         end else if (finish) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
         end else if (busy_q && wrap && left_q != '0) begin
            left_q <= left_q - BURST_W'(1);
         end
      end
   end

   p_start_clears_done_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (start && !stop && !busy_q) |=> (busy_q && !done_q));
   p_done_at_burst_end_r6 : assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done_q) |-> ($past(busy_q) && !busy_q && $past(wrap)));
   p_forever_holds_r5 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && mode_q == RUN_FOREVER && !stop) |=> busy_q);
endmodule

// File: rtl/pwm_burst_gen.sv
module pwm_burst_gen #(
   parameter int CNT_W   = 16,
   parameter int BURST_W = 16,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cfg_mode,
   input  logic               cfg_polarity,
   input  logic [CNT_W-1:0]   cfg_period,
   input  logic [CNT_W-1:0]   cfg_width,
   input  logic [BURST_W-1:0] cfg_burst,
   input  logic               start,
   input  logic               stop,
   output logic               pwm_out,
   output logic               busy,
   output logic               done
);
   if (CNT_W < 2) begin : g_bad_cnt_w
      $error("pwm_burst_gen: CNT_W must be at least 2");
   end
   if (BURST_W < 1) begin : g_bad_burst_w
      $error("pwm_burst_gen: BURST_W must be at least 1");
   end

   logic             accept, wrap, busy_q, done_q;
   logic [CNT_W-1:0] per_sh, wid_sh, cnt_q;
   logic             pol_sh, level;

   pwm_burst_seq #(.BURST_W(BURST_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .stop(stop),
      .mode_in(cfg_mode), .burst_in(cfg_burst), .wrap(wrap),
      .accept(accept), .busy_q(busy_q), .done_q(done_q)
   );

   pwm_shadow_regs #(.CNT_W(CNT_W)) u_shadow (
      .clk(clk), .rst_n(rst_n), .load(accept || wrap),
      .per_in(cfg_period), .wid_in(cfg_width), .pol_in(cfg_polarity),
      .per_sh(per_sh), .wid_sh(wid_sh), .pol_sh(pol_sh)
   );

   pwm_period_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .clr(accept), .run(busy_q),
      .per_sh(per_sh), .cnt_q(cnt_q), .wrap(wrap)
   );

   // Active phase first; polarity flips both levels
   assign level = busy_q ? ((cnt_q < wid_sh) ^ pol_sh) : cfg_polarity;
   assign busy  = busy_q;
   assign done  = done_q;

   if (OUT_REG) begin : g_out_reg
      logic out_q, seen_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            out_q  <= 1'b0;
            seen_q <= 1'b0;
         end else begin
            out_q  <= level;
            seen_q <= 1'b1;
         end
      end
      assign pwm_out = out_q;

      p_idle_level_r1 : assert property (@(posedge clk) disable iff (!rst_n)
         (seen_q && !busy_q && !$past(busy_q)) |-> (pwm_out == $past(cfg_polarity)));
   end else begin : g_out_comb
      assign pwm_out = level;
   end

   p_stop_halts_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && stop) |=> (!busy_q && !done_q));
   p_restart_ignored_r10 : assert property (@(posedge clk) disable iff (!rst_n)
      (busy_q && start && !stop && !wrap) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: tb/pwm_burst_gen_bench.sv
`timescale 1ns/1ps
module pwm_burst_gen_bench;
   localparam int CNT_W   = 16;
   localparam int BURST_W = 16;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cfg_mode = 1'b0;
   logic               cfg_polarity = 1'b0;
   logic [CNT_W-1:0]   cfg_period = '0;
   logic [CNT_W-1:0]   cfg_width = '0;
   logic [BURST_W-1:0] cfg_burst = '0;
   logic               start = 1'b0;
   logic               stop = 1'b0;
   logic               pwm_out, busy, done;

   int checks = 0;
   int fails  = 0;
   bit finished = 1'b0;

   always #2.5 clk = ~clk;

   pwm_burst_gen #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_pwm_burst_gen (
      .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_polarity(cfg_polarity),
      .cfg_period(cfg_period), .cfg_width(cfg_width), .cfg_burst(cfg_burst),
      .start(start), .stop(stop), .pwm_out(pwm_out), .busy(busy), .done(done)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // Run one waveform and compare every count against the expected pattern
   task automatic play(input int p, input int w, input int n, input bit burst_mode,
                       input bit pol, input int ncyc, input int stop_j,
                       input int restart_j, input string tag);
      int nn;
      int total;
      bit in_run, exp_out, exp_busy, exp_done;
      nn    = (n == 0) ? 1 : n;
      total = nn * p;
      @(negedge clk);
      cfg_mode     = burst_mode;
      cfg_polarity = pol;
      cfg_period   = CNT_W'(p);
      cfg_width    = CNT_W'(w);
      cfg_burst    = BURST_W'(n);
      start        = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy == 1'b1, {tag, " R2 busy after start"}, busy, 1);
      chk(done == 1'b0, {tag, " R2 done cleared"}, done, 0);
      chk(pwm_out == pol, {tag, " R2 idle before first pulse"}, pwm_out, pol);
      for (int j = 0; j < ncyc; j++) begin
         @(negedge clk);
         in_run   = ((stop_j < 0) || (j < stop_j + 2)) && (!burst_mode || (j < total));
         exp_out  = in_run ? (((j % p) < w) ^ pol) : pol;
         exp_busy = ((stop_j < 0) || (j <= stop_j)) && (!burst_mode || (j + 1 < total));
         exp_done = burst_mode && (stop_j < 0) && (j + 1 >= total);
         chk(pwm_out == exp_out, $sformatf("%s R3 wave j=%0d", tag, j), pwm_out, exp_out);
         chk(busy == exp_busy, $sformatf("%s R6 busy j=%0d", tag, j), busy, exp_busy);
         chk(done == exp_done, $sformatf("%s R6 done j=%0d", tag, j), done, exp_done);
         stop  = (j == stop_j);
         start = (j == restart_j);
      end
      stop  = 1'b0;
      start = 1'b0;
      if (busy) begin
         @(negedge clk); stop = 1'b1;
         @(negedge clk); stop = 1'b0;
      end
      repeat (2) @(negedge clk);
   endtask

   task automatic t_reset;
      chk(busy == 1'b0, "R1 busy after reset", busy, 0);
      chk(done == 1'b0, "R1 done after reset", done, 0);
      chk(pwm_out == 1'b0, "R1 out after reset", pwm_out, 0);
      cfg_polarity = 1'b1;
      repeat (2) @(negedge clk);
      chk(pwm_out == 1'b1, "R1 R7 idle follows polarity", pwm_out, 1);
      cfg_polarity = 1'b0;
      repeat (2) @(negedge clk);
      chk(pwm_out == 1'b0, "R1 idle back to low", pwm_out, 0);
   endtask

   task automatic t_burst;
      play(4, 1, 3, 1'b1, 1'b0, 16, -1, 2, "R6 burst3 R10 restart");
      play(3, 2, 0, 1'b1, 1'b0, 6, -1, -1, "R6 burst0");
   endtask

   task automatic t_forever_stop;
      play(5, 2, 1, 1'b0, 1'b1, 20, 13, -1, "R5 R7 R8 forever neg");
      play(6, 3, 2, 1'b1, 1'b0, 10, 4, -1, "R8 burst stop");
   endtask

   task automatic t_extremes;
      play(4, 0, 2, 1'b1, 1'b0, 10, -1, -1, "R4 width0");
      play(4, 7, 2, 1'b1, 1'b0, 10, -1, -1, "R4 width over");
   endtask

   task automatic t_change;
      bit e;
      @(negedge clk);
      cfg_mode = 1'b0; cfg_polarity = 1'b0;
      cfg_period = CNT_W'(5); cfg_width = CNT_W'(2);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      for (int j = 0; j < 14; j++) begin
         @(negedge clk);
         e = (j < 5) ? (j < 2) : (((j - 5) % 3) < 1);
         chk(pwm_out == e, $sformatf("R9 shadow j=%0d", j), pwm_out, e);
         if (j == 1) begin
            cfg_period = CNT_W'(3);
            cfg_width  = CNT_W'(1);
         end
      end
      stop = 1'b1;
      @(negedge clk); stop = 1'b0;
      repeat (2) @(negedge clk);
      chk(busy == 1'b0, "R8 stopped after R9 run", busy, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_burst();
      t_forever_stop();
      t_extremes();
      t_change();
      if (!finished) begin
         finished = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      #100000;
      if (!finished) begin
         finished = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule